// File: doc/BRIEF.md
# Low-Power Mode Control Register Unit

This unit is a 16-bit system control register that decides whether the processor core may enter its stop and wait low-power states. Software writes it through a simple synchronous register port. The core presents stop-request and wait-request pulses. The unit passes each request on as a gated entry signal only when the matching block bit is clear. Each mode field has its own lock bit. Once the lock bit is set, the field cannot change until the next system reset. This lets boot code fix the low-power policy so that later software cannot alter it.

The same register holds three more controls. The first is a debug-clock override that forces the debug clock enable on even when the debug TAP is idle. The second is a software-reset trigger. It sends a one-cycle request to the reset controller and always reads back as zero. A second, read-only word records the cause of the most recent system reset as one-hot bits. Both words and the cause latch take their state from the synchronous active-low system reset.

Top module: `lpm_power_ctrl`

## Requirements
- R1: Address 0 reads the control word and bits 15 to 6 read as zero, whatever value was written to them.
- R2: Control bit 5 is the debug-clock override and resets to 0. `dbg_clk_en` is high when bit 5 is 1 or `tap_active` is high.
- R3: Writing 1 to control bit 4 drives `soft_rst_pulse` high for exactly the one cycle after the write edge. Bit 4 always reads 0, including in that cycle.
- R4: Control bit 2 is the stop block bit. `stop_go` equals `stop_req` when bit 2 is 0 and is low when bit 2 is 1.
- R5: Control bit 0 is the wait block bit. `wait_go` equals `wait_req` when bit 0 is 0 and is low when bit 0 is 1.
- R6: Bit 3 locks the stop field (bits 3:2) and bit 1 locks the wait field (bits 1:0). A field whose lock bit reads 1 ignores all further writes until reset.
- R7: A write that reaches a locked field still updates the unlocked fields of the control word in the same cycle.
- R8: Any system reset clears every control bit, including both lock bits, so the fields become writable again.
- R9: Address 1 reads the reset status word. Bit 0 means power-on, bit 1 external pin, bit 2 watchdog and bit 3 software reset. Bits 15 to 4 read zero. The word is rewritten on every cycle that has `rst_n` low, from the cause inputs.
- R10: When several cause inputs are high during reset, only one status bit is set. The priority is power-on, then watchdog, then software, then pin. With no cause input high, the status word is zero.
- R11: Outside reset, the status word keeps its value through any bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cause_por | input | 1 | Reset cause: power-on, sampled while rst_n is low |
| cause_pin | input | 1 | Reset cause: external reset pin |
| cause_wdog | input | 1 | Reset cause: watchdog timeout |
| cause_soft | input | 1 | Reset cause: software request |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 1 | Word address: 0 control, 1 reset status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when not selected) |
| stop_req | input | 1 | Core request to enter stop mode |
| wait_req | input | 1 | Core request to enter wait mode |
| tap_active | input | 1 | Debug TAP currently enabled |
| stop_go | output | 1 | Gated stop-mode entry |
| wait_go | output | 1 | Gated wait-mode entry |
| dbg_clk_en | output | 1 | Debug clock enable to the core |
| soft_rst_pulse | output | 1 | One-cycle software reset request |

## Verification
The hardest case to reach from the ports is a partly locked word. In this case one field is frozen while a single write changes the other field and the debug bit. The stimulus locks the stop field first. It then writes a value that tries to clear the stop field and set the wait field, and checks the read-back and both gated outputs bit by bit. A second sequence resets with the software cause and confirms that the locks are gone by rewriting the fields. Priority between coinciding causes is tested by holding several cause inputs high through a single reset cycle.

// File: rtl/lpm_pkg.sv
// lpm_pkg: shared constants for the low-power mode control unit.
// Assumes a 16-bit register word and a fixed control bit layout,
// because the gating and lock logic decode individual bits.
package lpm_pkg;
    localparam int DATA_W    = 16;
    localparam int FIELD_W   = 2;            // block bit + lock bit
    localparam int NUM_FLD   = 2;            // field 0 = wait, field 1 = stop
    localparam int BIT_SWRST = 4;
    localparam int BIT_DBG   = 5;
    localparam int CTRL_W    = BIT_DBG + 1;  // implemented control bits

    // Position of each cause inside the status word.
    typedef enum logic [1:0] {
        CAUSE_POR  = 2'd0,
        CAUSE_PIN  = 2'd1,
        CAUSE_WDOG = 2'd2,
        CAUSE_SOFT = 2'd3
    } cause_idx_e;

    localparam int CAUSE_W = 4;
endpackage

// File: rtl/lpm_mode_field.sv
// lpm_mode_field: one two-bit mode-disable field with a sticky lock.
// The low bit blocks the mode, the high bit freezes the field until
// the next synchronous reset. Assumes wr_en is a single-cycle strobe.
module lpm_mode_field
    import lpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_val,
    output logic               blk_q,
    output logic               lock_q
);

    // Field storage: cleared on reset, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= 1'b0;
            lock_q <= 1'b0;
        end else if (wr_en && !lock_q) begin
            blk_q  <= wr_val[0];
            lock_q <= wr_val[1];
        end
    end

    // A locked field never changes and stays locked until reset.
    AST_FIELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> (lock_q && $stable(blk_q)));   // R6

    // Reset releases the lock and the block bit.
    AST_LOCK_RELEASED: assert property (@(posedge clk)
        !rst_n |=> (!lock_q && !blk_q));          // R8

endmodule

// File: rtl/lpm_reset_cause.sv
// lpm_reset_cause: latches a one-hot record of why the last reset
// happened. While rst_n is low the cause inputs are sampled each
// cycle. The highest-priority active cause wins (power-on, watchdog,
// software, pin). Assumes the reset controller holds the cause inputs
// valid for the whole reset.
module lpm_reset_cause
    import lpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause_in,
    output logic [CAUSE_W-1:0] status_q
);

    logic [CAUSE_W-1:0] pick;

    // Priority pick of a single cause bit.
    always_comb begin
        pick = '0;
        if (cause_in[CAUSE_POR])       pick[CAUSE_POR]  = 1'b1;
        else if (cause_in[CAUSE_WDOG]) pick[CAUSE_WDOG] = 1'b1;
        else if (cause_in[CAUSE_SOFT]) pick[CAUSE_SOFT] = 1'b1;
        else if (cause_in[CAUSE_PIN])  pick[CAUSE_PIN]  = 1'b1;
    end

    // Status capture: reloaded during reset, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= pick;
    end

    // Reset cause word has at most one bit set.
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_q));                                  // R10

    // Power-on during reset always wins.
    AST_POR_WINS: assert property (@(posedge clk)
        (!rst_n && cause_in[CAUSE_POR]) |=> status_q[CAUSE_POR]); // R10

    // Outside reset the record is stable.
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(status_q));                         // R11

endmodule

// File: rtl/lpm_power_ctrl.sv
// lpm_power_ctrl: memory-mapped low-power mode control register.
// Address 0 holds the control word (debug clock override, software
// reset trigger, stop and wait fields with locks). Address 1 holds
// the read-only reset cause word. Assumes a single-cycle synchronous
// register port with combinational read data.
module lpm_power_ctrl
    import lpm_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_por,
    input  logic              cause_pin,
    input  logic              cause_wdog,
    input  logic              cause_soft,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_req,
    input  logic              wait_req,
    input  logic              tap_active,
    output logic              stop_go,
    output logic              wait_go,
    output logic              dbg_clk_en,
    output logic              soft_rst_pulse
);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

    logic               ctrl_wr;
    logic               dbg_q;
    logic [NUM_FLD-1:0] fld_blk;
    logic [NUM_FLD-1:0] fld_lock;
    logic [CAUSE_W-1:0] cause_vec;
    logic [CAUSE_W-1:0] status_q;
    logic [CTRL_W-1:0]  ctrl_view;
    logic               unused_wdata;

    // Write decode for the control word.
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);

    // Reserved write bits are deliberately dropped.
    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

    // Mode fields: field 0 at bits 1:0 (wait), field 1 at bits 3:2 (stop).
    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
        lpm_mode_field u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ctrl_wr),
            .wr_val (bus_wdata[g*FIELD_W +: FIELD_W]),
            .blk_q  (fld_blk[g]),
            .lock_q (fld_lock[g])
        );
    end

    // Debug clock override bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       dbg_q <= 1'b0;
        else if (ctrl_wr) dbg_q <= bus_wdata[BIT_DBG];
    end

    // Software reset request: one-cycle pulse, nothing is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_pulse <= 1'b0;
        else        soft_rst_pulse <= ctrl_wr && bus_wdata[BIT_SWRST];
    end

    // Cause vector in status bit order.
    always_comb begin
        cause_vec             = '0;
        cause_vec[CAUSE_POR]  = cause_por;
        cause_vec[CAUSE_PIN]  = cause_pin;
        cause_vec[CAUSE_WDOG] = cause_wdog;
        cause_vec[CAUSE_SOFT] = cause_soft;
    end

    lpm_reset_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_in (cause_vec),
        .status_q (status_q)
    );

    // Control word view, trigger bit always zero.
    always_comb begin
        ctrl_view            = '0;
        ctrl_view[0]         = fld_blk[0];
        ctrl_view[1]         = fld_lock[0];
        ctrl_view[2]         = fld_blk[1];
        ctrl_view[3]         = fld_lock[1];
        ctrl_view[BIT_SWRST] = 1'b0;
        ctrl_view[BIT_DBG]   = dbg_q;
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == ADDR_CTRL)      bus_rdata[CTRL_W-1:0]  = ctrl_view;
            else if (bus_addr == ADDR_STAT) bus_rdata[CAUSE_W-1:0] = status_q;
        end
    end

    // Mode-entry gating and debug clock enable.
    assign stop_go    = stop_req && !fld_blk[1];
    assign wait_go    = wait_req && !fld_blk[0];
    assign dbg_clk_en = dbg_q || tap_active;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:CTRL_W] == '0);                        // R1
    AST_TAP_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        tap_active |-> dbg_clk_en);                               // R2
    AST_SWRST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> $past(bus_sel && bus_wr && bus_wdata[BIT_SWRST])); // R3
    AST_SWRST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == ADDR_CTRL) |-> !bus_rdata[BIT_SWRST]);   // R3
    AST_STOP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req |-> !stop_go);                                  // R4
    AST_WAIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_req |-> !wait_go);                                  // R5

endmodule

// File: tb/lpm_power_ctrl_tb.sv
// Directed bench for lpm_power_ctrl: one task per scenario.
module lpm_power_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cause_por = 1'b0, cause_pin = 1'b0;
    logic        cause_wdog = 1'b0, cause_soft = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [0:0]  bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        stop_req = 1'b0, wait_req = 1'b0, tap_active = 1'b0;
    logic        stop_go, wait_go, dbg_clk_en, soft_rst_pulse;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    lpm_power_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cause_por(cause_por), .cause_pin(cause_pin),
        .cause_wdog(cause_wdog), .cause_soft(cause_soft),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_req(stop_req), .wait_req(wait_req), .tap_active(tap_active),
        .stop_go(stop_go), .wait_go(wait_go),
        .dbg_clk_en(dbg_clk_en), .soft_rst_pulse(soft_rst_pulse)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sys_reset(input logic por, input logic pin, input logic wd, input logic sw);
        @(negedge clk);
        rst_n = 1'b0; cause_por = por; cause_pin = pin; cause_wdog = wd; cause_soft = sw;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; cause_por = 0; cause_pin = 0; cause_wdog = 0; cause_soft = 0;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        sys_reset(1, 0, 0, 0);
        rd(0, d); chk("R8 ctrl after reset", d, 16'h0000);
        rd(1, d); chk("R9 status power-on", d, 16'h0001);
        tap_active = 0; #1;
        chk("R2 dbg off at reset", {15'd0, dbg_clk_en}, 16'd0);
    endtask

    task automatic t_gating();
        wr(0, 16'h0004);
        stop_req = 1; wait_req = 1; #1;
        chk("R4 stop blocked", {15'd0, stop_go}, 16'd0);
        chk("R5 wait passes", {15'd0, wait_go}, 16'd1);
        wr(0, 16'h0001); #1;
        chk("R4 stop passes", {15'd0, stop_go}, 16'd1);
        chk("R5 wait blocked", {15'd0, wait_go}, 16'd0);
        stop_req = 0; wait_req = 0;
    endtask

    task automatic t_lock();
        logic [15:0] d;
        sys_reset(0, 1, 0, 0);
        rd(1, d); chk("R9 status pin", d, 16'h0002);
        wr(0, 16'h000C);
        wr(0, 16'h0003);   // stop field locked, wait field free
        rd(0, d); chk("R7 partial write", d, 16'h000F);
        wr(0, 16'h0020);
        rd(0, d); chk("R6 both frozen, dbg set", d, 16'h002F);
        stop_req = 1; wait_req = 1; #1;
        chk("R6 stop still blocked", {15'd0, stop_go}, 16'd0);
        chk("R6 wait still blocked", {15'd0, wait_go}, 16'd0);
        stop_req = 0; wait_req = 0;
        rd(1, d); chk("R11 status held", d, 16'h0002);
    endtask

    task automatic t_lock_open();
        sys_reset(0, 0, 1, 0);
        wr(0, 16'h0008);   // lock stop field with entry allowed
        wr(0, 16'h0004);
        stop_req = 1; #1;
        chk("R6 locked open stop", {15'd0, stop_go}, 16'd1);
        stop_req = 0;
    endtask

    task automatic t_soft_reset();
        logic [15:0] d;
        wr(0, 16'h0010);
        chk("R3 pulse high", {15'd0, soft_rst_pulse}, 16'd1);
        rd(0, d); chk("R3 trigger reads zero", d & 16'h0010, 16'h0000);
        @(posedge clk); #1;
        chk("R3 pulse one cycle", {15'd0, soft_rst_pulse}, 16'd0);
    endtask

    task automatic t_release();
        logic [15:0] d;
        wr(0, 16'h000A);
        sys_reset(0, 0, 0, 1);
        rd(1, d); chk("R9 status soft", d, 16'h0008);
        rd(0, d); chk("R8 locks cleared", d, 16'h0000);
        wr(0, 16'h0005);
        rd(0, d); chk("R8 writable again", d, 16'h0005);
    endtask

    task automatic t_priority();
        logic [15:0] d;
        sys_reset(1, 1, 1, 1);
        rd(1, d); chk("R10 power-on wins", d, 16'h0001);
        sys_reset(0, 1, 1, 1);
        rd(1, d); chk("R10 watchdog next", d, 16'h0004);
        sys_reset(0, 1, 0, 1);
        rd(1, d); chk("R10 soft over pin", d, 16'h0008);
        sys_reset(0, 0, 0, 0);
        rd(1, d); chk("R10 no cause", d, 16'h0000);
    endtask

    task automatic t_debug_rsvd();
        logic [15:0] d;
        tap_active = 1; #1;
        chk("R2 tap drives clock", {15'd0, dbg_clk_en}, 16'd1);
        tap_active = 0; #1;
        chk("R2 tap idle", {15'd0, dbg_clk_en}, 16'd0);
        wr(0, 16'hFFE0); #1;
        chk("R2 override", {15'd0, dbg_clk_en}, 16'd1);
        rd(0, d); chk("R1 reserved read zero", d, 16'h0020);
        wr(1, 16'hFFFF);
        rd(1, d); chk("R11 status ignores write", d, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_gating();
        t_soft_reset();
        t_lock();
        t_lock_open();
        t_release();
        t_priority();
        t_debug_rsvd();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule